// File: doc/BRIEF.md
# Event and Interrupt Register Bank

This block is the host-visible register bank of a network controller. A small synchronous port lets the host write and read sixteen-bit registers by index. The bits in the bank behave in four different ways. Action bits fire a single pulse and read back as zero. Sticky event bits latch hardware strobes and clear when the host reads them. Status bits mirror live hardware levels. Two saturating counters, one for missed frames and one for collisions, also clear when read.

Per-event enable bits gate one level-sensitive interrupt line to the host. That line stays high while any enabled event is pending and is not yet read. A separate set of frame-acceptance bits is stored and driven out to the receive path. Those bits never take part in the interrupt.

The read side is a two-state host-port machine. In state HP_IDLE the port waits. A read moves the machine to HP_RESP, where the captured data is presented with a valid flag for one cycle. The transition HP_RESP to HP_RESP is taken on back-to-back reads, and HP_RESP to HP_IDLE is taken when no read follows. Clearing of event registers and counters happens on the same clock edge that captures the read data.

Top module: `evt_irq_regbank`

## Requirements
- R1: A write to index 0 raises `act_pulse[i]` for exactly one cycle, starting at the clock edge that takes the write, for each data bit i set in the write. The pulse repeats only when a new write sets the bit again.
- R2: Reading index 0 always returns 0x0000.
- R3: A one-cycle strobe on `rx_evt_strb[i]` sets bit i of the receive event register at index 4, and a strobe on `tx_evt_strb[i]` sets bit i of the transmit event register at index 5. This happens whatever the enable bits are, and the bit holds until the register is read.
- R4: A read of index 4 or 5 returns the accumulated bits and clears the whole register. A strobe that arrives in the same cycle as that read is not returned by it and remains set afterwards.
- R5: `irq` is high in every cycle in which some event bit is set while its enable bit is also set. Index 1 holds the receive enables and index 2 holds the transmit enables, bit for bit. `irq` goes low once reads have cleared every enabled pending bit.
- R6: Reading index 6 returns the value of `status_in` from the read cycle. Host writes to index 6 have no effect.
- R7: The counter at index 7 counts cycles with `miss_inc` high, and the counter at index 8 counts cycles with `coll_inc` high. A read returns the count, zero-extended, and clears it. An increment in the same cycle as the read leaves the count at 1.
- R8: Both counters stop at 2^CNT_W-1 instead of wrapping (1023 with the default parameters).
- R9: Index 3 holds frame-acceptance bits. They are readable, drive `accept_sel`, and never cause `irq`.
- R10: `host_rdata` and `host_rvalid` are valid in the cycle after the one in which `host_rd` is high. `host_rvalid` is low in any other cycle, and all outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Register index |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, one cycle after the read |
| host_rvalid | output | 1 | Read data valid |
| rx_evt_strb | input | EVT_W | Receive event strobes |
| tx_evt_strb | input | EVT_W | Transmit event strobes |
| status_in | input | DATA_W | Live hardware status levels |
| miss_inc | input | 1 | Missed-frame increment |
| coll_inc | input | 1 | Collision increment |
| act_pulse | output | NACT | One-cycle action pulses |
| accept_sel | output | DATA_W | Frame acceptance selection |
| irq | output | 1 | Level interrupt to host |

## Verification
Two pairs of functions can fall in the same clock cycle. The first is a hardware event strobe and the host read that clears the same event register. The second is a counter increment and the read that clears that counter. The bench provokes each pair by raising the strobe or increment together with the read. It then judges the result in two steps: the read must return the value from before that cycle, and a second read must return exactly the new event, or a count of 1.

// File: rtl/eirb_pkg.sv
package eirb_pkg;

    // Register indices; the bank decodes these values.
    typedef enum logic [3:0] {
        RG_CMD     = 4'd0,
        RG_RX_EN   = 4'd1,
        RG_TX_EN   = 4'd2,
        RG_ACCEPT  = 4'd3,
        RG_RX_EVT  = 4'd4,
        RG_TX_EVT  = 4'd5,
        RG_STATUS  = 4'd6,
        RG_MISS    = 4'd7,
        RG_COLL    = 4'd8
    } reg_idx_e;

    // Host-port read sequencing.
    typedef enum logic [0:0] {
        HP_IDLE = 1'b0,
        HP_RESP = 1'b1
    } hp_state_e;

endpackage

// File: rtl/eirb_sticky.sv
module eirb_sticky #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] strobe,
    input  logic         clr,
    output logic [W-1:0] q
);

    logic [W-1:0] base;

    // A clear wipes held bits, but strobes in the same cycle survive.
    always_comb begin
        base = clr ? '0 : q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= base | strobe;
        end
    end

endmodule

// File: rtl/eirb_satcnt.sv
module eirb_satcnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic at_top;

    always_comb begin
        at_top = (q == TOP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= inc ? W'(1) : '0;
        end else if (inc && !at_top) begin
            q <= q + W'(1);
        end
    end

endmodule

// File: rtl/eirb_actonce.sv
module eirb_actonce #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [N-1:0] bits,
    output logic [N-1:0] pulse
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= '0;
        end else begin
            pulse <= fire ? bits : '0;
        end
    end

endmodule

// File: rtl/evt_irq_regbank.sv
module evt_irq_regbank
    import eirb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int EVT_W  = 16,
    parameter int NACT   = 4,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic [EVT_W-1:0]  rx_evt_strb,
    input  logic [EVT_W-1:0]  tx_evt_strb,
    input  logic [DATA_W-1:0] status_in,
    input  logic              miss_inc,
    input  logic              coll_inc,
    output logic [NACT-1:0]   act_pulse,
    output logic [DATA_W-1:0] accept_sel,
    output logic              irq
);

    localparam int NGRP = 2;
    localparam int NCNT = 2;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_idx_e r);
        return a == ADDR_W'(r);
    endfunction

    // Write and read decode.
    logic wr_cmd, wr_rx_en, wr_tx_en, wr_accept;
    logic rd_rx_evt, rd_tx_evt, rd_miss, rd_coll;

    always_comb begin
        wr_cmd    = host_wr && hit(host_addr, RG_CMD);
        wr_rx_en  = host_wr && hit(host_addr, RG_RX_EN);
        wr_tx_en  = host_wr && hit(host_addr, RG_TX_EN);
        wr_accept = host_wr && hit(host_addr, RG_ACCEPT);
        rd_rx_evt = host_rd && hit(host_addr, RG_RX_EVT);
        rd_tx_evt = host_rd && hit(host_addr, RG_TX_EVT);
        rd_miss   = host_rd && hit(host_addr, RG_MISS);
        rd_coll   = host_rd && hit(host_addr, RG_COLL);
    end

    // Configuration and control storage.
    logic [EVT_W-1:0]  en_rx_q, en_tx_q;
    logic [DATA_W-1:0] accept_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_rx_q  <= '0;
            en_tx_q  <= '0;
            accept_q <= '0;
        end else begin
            if (wr_rx_en)  en_rx_q  <= host_wdata[EVT_W-1:0];
            if (wr_tx_en)  en_tx_q  <= host_wdata[EVT_W-1:0];
            if (wr_accept) accept_q <= host_wdata;
        end
    end

    assign accept_sel = accept_q;

    // Act-once action bits.
    eirb_actonce #(.N(NACT)) u_act (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (wr_cmd),
        .bits  (host_wdata[NACT-1:0]),
        .pulse (act_pulse)
    );

    // Sticky clear-on-read event groups.
    logic [EVT_W-1:0] evt_strb [NGRP];
    logic [EVT_W-1:0] evt_q    [NGRP];
    logic [NGRP-1:0]  evt_clr;

    assign evt_strb[0] = rx_evt_strb;
    assign evt_strb[1] = tx_evt_strb;
    assign evt_clr     = {rd_tx_evt, rd_rx_evt};

    for (genvar g = 0; g < NGRP; g++) begin : g_evt
        eirb_sticky #(.W(EVT_W)) u_evt (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (evt_strb[g]),
            .clr    (evt_clr[g]),
            .q      (evt_q[g])
        );
    end

    logic [EVT_W-1:0] evt_rx_q, evt_tx_q;
    assign evt_rx_q = evt_q[0];
    assign evt_tx_q = evt_q[1];

    // Saturating clear-on-read counters.
    logic [NCNT-1:0]  cnt_inc, cnt_clr;
    logic [CNT_W-1:0] cnt_q [NCNT];

    assign cnt_inc = {coll_inc, miss_inc};
    assign cnt_clr = {rd_coll, rd_miss};

    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
        eirb_satcnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[c]),
            .clr   (cnt_clr[c]),
            .q     (cnt_q[c])
        );
    end

    logic [CNT_W-1:0] cnt_miss_q;
    assign cnt_miss_q = cnt_q[0];

    // Enable-gated level interrupt.
    logic rx_pend, tx_pend;

    always_comb begin
        rx_pend = |(evt_rx_q & en_rx_q);
        tx_pend = |(evt_tx_q & en_tx_q);
        irq     = rx_pend || tx_pend;
    end

    // Read multiplexer.
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        unique case (host_addr)
            ADDR_W'(RG_CMD):    rd_mux = '0;
            ADDR_W'(RG_RX_EN):  rd_mux = DATA_W'(en_rx_q);
            ADDR_W'(RG_TX_EN):  rd_mux = DATA_W'(en_tx_q);
            ADDR_W'(RG_ACCEPT): rd_mux = accept_q;
            ADDR_W'(RG_RX_EVT): rd_mux = DATA_W'(evt_rx_q);
            ADDR_W'(RG_TX_EVT): rd_mux = DATA_W'(evt_tx_q);
            ADDR_W'(RG_STATUS): rd_mux = status_in;
            ADDR_W'(RG_MISS):   rd_mux = DATA_W'(cnt_q[0]);
            ADDR_W'(RG_COLL):   rd_mux = DATA_W'(cnt_q[1]);
            default:            rd_mux = '0;
        endcase
    end

    // Host-port state machine.
    hp_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            HP_IDLE: state_d = host_rd ? HP_RESP : HP_IDLE;
            HP_RESP: state_d = host_rd ? HP_RESP : HP_IDLE;
            default: state_d = HP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= host_rd ? rd_mux : '0;
        end
    end

    assign host_rdata  = rdata_q;
    assign host_rvalid = (state_q == HP_RESP);

endmodule

// File: rtl/eirb_checker.sv
module eirb_checker #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int EVT_W  = 16,
    parameter int NACT   = 4,
    parameter int CNT_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic              host_rvalid,
    input logic [DATA_W-1:0] status_in,
    input logic [NACT-1:0]   act_pulse,
    input logic              irq,
    input logic [EVT_W-1:0]  en_rx_q,
    input logic [EVT_W-1:0]  en_tx_q,
    input logic [EVT_W-1:0]  evt_rx_q,
    input logic [EVT_W-1:0]  evt_tx_q,
    input logic [CNT_W-1:0]  cnt_miss_q
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    p_pulse_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|act_pulse) |-> ($past(host_wr && host_addr == ADDR_W'(0))
                          && act_pulse == $past(host_wdata[NACT-1:0])));

    p_cmd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && $past(host_addr) == ADDR_W'(0)) |-> host_rdata == '0);

    p_evt_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && host_addr == ADDR_W'(4)) |=> ((evt_rx_q & $past(evt_rx_q)) == $past(evt_rx_q)));

    p_irq_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(evt_rx_q & en_rx_q)) || (|(evt_tx_q & en_tx_q))) |-> irq);

    p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rx_q == '0 && en_tx_q == '0) |-> !irq);

    p_status_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == ADDR_W'(6)) |=> host_rdata == $past(status_in));

    p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_miss_q == TOP && !(host_rd && host_addr == ADDR_W'(7))) |=> cnt_miss_q == TOP);

    p_rvalid_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid);

    p_rvalid_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rvalid);

endmodule

bind evt_irq_regbank eirb_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .EVT_W  (EVT_W),
    .NACT   (NACT),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .status_in   (status_in),
    .act_pulse   (act_pulse),
    .irq         (irq),
    .en_rx_q     (en_rx_q),
    .en_tx_q     (en_tx_q),
    .evt_rx_q    (evt_rx_q),
    .evt_tx_q    (evt_tx_q),
    .cnt_miss_q  (cnt_miss_q)
);

// File: tb/evt_irq_regbank_bench.sv
module evt_irq_regbank_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic [15:0] rx_evt_strb = '0;
    logic [15:0] tx_evt_strb = '0;
    logic [15:0] status_in = '0;
    logic        miss_inc = 1'b0;
    logic        coll_inc = 1'b0;
    logic [3:0]  act_pulse;
    logic [15:0] accept_sel;
    logic        irq;

    int nchk = 0;
    int nerr = 0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_regbank u_evt_irq_regbank (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .rx_evt_strb (rx_evt_strb),
        .tx_evt_strb (tx_evt_strb),
        .status_in   (status_in),
        .miss_inc    (miss_inc),
        .coll_inc    (coll_inc),
        .act_pulse   (act_pulse),
        .accept_sel  (accept_sel),
        .irq         (irq)
    );

    task automatic check(input logic ok, input string tag, input logic [15:0] got, input logic [15:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: pops expected read values as results appear.
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected rvalid", 16'(host_rvalid), 16'h0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(host_rdata === e, t, host_rdata, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] e, input string t);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic rx_strobe(input logic [15:0] v);
        @(negedge clk);
        rx_evt_strb = v;
        @(negedge clk);
        rx_evt_strb = '0;
    endtask

    task automatic tx_strobe(input logic [15:0] v);
        @(negedge clk);
        tx_evt_strb = v;
        @(negedge clk);
        tx_evt_strb = '0;
    endtask

    task automatic finish_run();
        check(exp_q.size() == 0, "R10 pending reads drained", 16'(exp_q.size()), 16'h0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(irq == 1'b0, "R10 reset irq", 16'(irq), 16'h0);
        check(act_pulse == '0, "R10 reset act_pulse", 16'(act_pulse), 16'h0);
        check(host_rvalid == 1'b0, "R10 reset rvalid", 16'(host_rvalid), 16'h0);
        check(accept_sel == '0, "R10 reset accept", accept_sel, 16'h0);
        rd(4'd4, 16'h0000, "R10 reset rx events");

        // R1 act-once pulses
        wr(4'd0, 16'h0005);
        check(act_pulse == 4'h5, "R1 pulse after write", 16'(act_pulse), 16'h5);
        @(negedge clk);
        check(act_pulse == 4'h0, "R1 pulse one cycle", 16'(act_pulse), 16'h0);
        repeat (3) @(negedge clk);
        check(act_pulse == 4'h0, "R1 no repeat", 16'(act_pulse), 16'h0);
        wr(4'd0, 16'h000A);
        check(act_pulse == 4'hA, "R1 rewrite fires", 16'(act_pulse), 16'hA);
        // R2
        rd(4'd0, 16'h0000, "R2 cmd reads zero");

        // R3 event sets without enable; R5 enable gating
        wr(4'd1, 16'h0004);
        rx_strobe(16'h0008);
        check(irq == 1'b0, "R5 unenabled event no irq", 16'(irq), 16'h0);
        rd(4'd4, 16'h0008, "R3 event set without enable");
        rx_strobe(16'h0004);
        check(irq == 1'b1, "R5 enabled event irq", 16'(irq), 16'h1);
        rd(4'd4, 16'h0004, "R4 read returns event");
        check(irq == 1'b0, "R5 irq drops after read", 16'(irq), 16'h0);
        rd(4'd4, 16'h0000, "R4 register cleared");

        // R5 level on transmit side
        wr(4'd2, 16'h0001);
        tx_strobe(16'h0001);
        repeat (3) @(negedge clk);
        check(irq == 1'b1, "R5 irq held as level", 16'(irq), 16'h1);
        rd(4'd5, 16'h0001, "R3 tx event");
        check(irq == 1'b0, "R5 irq clears on tx read", 16'(irq), 16'h0);

        // R4 coincident strobe and clearing read
        rx_strobe(16'h0001);
        @(negedge clk);
        rx_evt_strb = 16'h0002; host_rd = 1'b1; host_addr = 4'd4;
        exp_q.push_back(16'h0001); tag_q.push_back("R4 coincident read old value");
        @(negedge clk);
        rx_evt_strb = '0; host_rd = 1'b0;
        rd(4'd4, 16'h0002, "R4 coincident strobe kept");

        // R6 status live, writes ignored
        status_in = 16'h00A5;
        wr(4'd6, 16'hFFFF);
        rd(4'd6, 16'h00A5, "R6 status after write");
        status_in = 16'h1234;
        rd(4'd6, 16'h1234, "R6 status tracks input");

        // R7 counters
        @(negedge clk); miss_inc = 1'b1;
        repeat (5) @(negedge clk); miss_inc = 1'b0;
        rd(4'd7, 16'd5, "R7 miss count");
        rd(4'd7, 16'd0, "R7 miss cleared");
        @(negedge clk); miss_inc = 1'b1;
        repeat (3) @(negedge clk);
        host_rd = 1'b1; host_addr = 4'd7;
        exp_q.push_back(16'd3); tag_q.push_back("R7 coincident read old count");
        @(negedge clk);
        host_rd = 1'b0; miss_inc = 1'b0;
        rd(4'd7, 16'd1, "R7 coincident increment kept");

        // R8 saturation
        @(negedge clk); coll_inc = 1'b1;
        repeat (1030) @(negedge clk); coll_inc = 1'b0;
        rd(4'd8, 16'd1023, "R8 collision saturates");
        rd(4'd8, 16'd0, "R8 cleared after saturation");

        // R9 accept bits independent of interrupt
        wr(4'd1, 16'h0000);
        wr(4'd2, 16'h0000);
        wr(4'd3, 16'hFFFF);
        rx_strobe(16'hFFFF);
        tx_strobe(16'hFFFF);
        check(irq == 1'b0, "R9 accept bits no irq", 16'(irq), 16'h0);
        check(accept_sel == 16'hFFFF, "R9 accept output", accept_sel, 16'hFFFF);
        rd(4'd3, 16'hFFFF, "R9 accept readback");
        rd(4'd4, 16'hFFFF, "R9 rx events pending");
        rd(4'd5, 16'hFFFF, "R9 tx events pending");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule